// File: doc/BRIEF.md
# Software SMI Periodic Timer

This block requests a software system-management interrupt at a fixed, selectable interval. A 2-bit rate field picks one of four intervals: about 1.5 ms, 16 ms, 32 ms or 64 ms. The field sits in an 8-bit configuration register. The timer does not count clock cycles. It counts a tick strobe supplied from outside. The parameter `TICKS_PER_MS` gives the number of ticks in one millisecond, so a simulation can use a fast tick and shorter intervals. While the enable input is high, the timer counts ticks. When the chosen interval has elapsed, it raises `smi_timeout` for one clock cycle and begins the next interval at once.

The configuration register sits in the RTC domain. Only `rtc_rst_n` clears it. The main reset `rst_n` returns the timer state machine to idle and leaves the rate field as it was. Routing the request to a handler is done elsewhere.

The controller has three states:
- **IDLE:** the count is held at zero and the interval length follows the register.
- **RUN:** ticks are counted.
- **EXPIRE:** the one cycle in which the request is raised.

The transitions are:
- `start` (IDLE→RUN, enable high).
- `elapse` (RUN→EXPIRE, a tick arrives on the last count).
- `resume` (EXPIRE→RUN).
- `halt` (RUN or EXPIRE→IDLE, enable low).

Top module: `swsmi_timer`

## Requirements
- R1: A write stores `wr_data[7:6]` as the rate field. `cfg_rdata[7:6]` returns the field and `cfg_rdata[5:0]` always reads 0. The write takes effect at the clock edge where `wr_en` is sampled high.
- R2: Asserting `rtc_rst_n` low clears the register to 8'h00, which selects the shortest interval.
- R3: Asserting `rst_n` low leaves the rate field unchanged. It holds `smi_timeout` low and discards the progress of the current interval. Counting starts from zero again after release.
- R4: Interval length in ticks is ceil(1.5·T), 16·T, 32·T and 64·T for codes 00, 01, 10 and 11, where T is `TICKS_PER_MS`. With T=2 these are 3, 32, 64 and 128 ticks.
- R5: With ticks on every cycle, the edge that moves IDLE to RUN is edge E0. The first pulse is visible in the cycle after edge E0+P, and later pulses follow every P cycles while the enable stays high.
- R6: `smi_timeout` is high for exactly one clock cycle per expiry.
- R7: While `tmr_en` is low, no pulse is raised and the count stays at zero. A fresh enable starts a full interval from zero.
- R8: A clock edge with `tick` low does not advance the count, so each tick-less edge delays the pulse by one cycle.
- R9: A rate write made during an interval leaves that interval's length unchanged. The new length applies from the next restart onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Main reset, active low, asynchronous; resets the timer only |
| rtc_rst_n | input | 1 | RTC-domain reset, active low, asynchronous; clears the register |
| tmr_en | input | 1 | Timer enable |
| tick | input | 1 | Time-base strobe, `TICKS_PER_MS` per millisecond |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data; bits 7:6 are the rate field |
| cfg_rdata | output | 8 | Register contents |
| smi_timeout | output | 1 | One-cycle interval-expiry request |

## Verification
Internal state errors show up at the ports in the following ways:
- **Wrong interval length:** a counter that is off by one, or the wrong length latched, moves every pulse by a whole number of cycles. The first pulse after enable already shows the error, within P+1 cycles.
- **Stuck state machine:** a machine stuck in EXPIRE shows as a pulse two cycles wide on the very next cycle.
- **Wrong latch timing for the length:** if the length is latched at the write rather than at the restart, the pulse in progress moves, because it ends at the new length.
- **Reset domains crossed:** if a reset touches the wrong domain, `cfg_rdata` changes after the main reset, or keeps its old value after the RTC-domain reset.

// File: rtl/swsmi_pkg.sv
package swsmi_pkg;

    typedef enum logic [1:0] {
        TS_IDLE   = 2'd0,
        TS_RUN    = 2'd1,
        TS_EXPIRE = 2'd2
    } tmr_state_e;

    localparam int CFG_W     = 8;
    localparam int RATE_LSB  = 6;
    localparam int RATE_W    = 2;
    localparam int NUM_RATES = 1 << RATE_W;

    // Interval length in half-millisecond units for each rate code.
    function automatic int rate_halfms(input int code);
        case (code)
            0:       return 3;
            1:       return 32;
            2:       return 64;
            default: return 128;
        endcase
    endfunction

    // Ticks for a rate code, rounded up.
    function automatic int rate_ticks(input int code, input int ticks_per_ms);
        return (rate_halfms(code) * ticks_per_ms + 1) / 2;
    endfunction

endpackage

// File: rtl/swsmi_cfg_reg.sv
module swsmi_cfg_reg
    import swsmi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rtc_rst_n,
    input  logic                 wr_en,
    input  logic [CFG_W-1:0]     wr_data,
    output logic [RATE_W-1:0]    rate_sel,
    output logic [CFG_W-1:0]     rdata
);

    logic [RATE_W-1:0] rate_q;

    // Only the RTC-domain reset clears the rate field.
    always_ff @(posedge clk or negedge rtc_rst_n) begin
        if (!rtc_rst_n) begin
            rate_q <= '0;
        end else if (wr_en) begin
            rate_q <= wr_data[RATE_LSB +: RATE_W];
        end
    end

    assign rate_sel = rate_q;
    assign rdata    = CFG_W'(rate_q) << RATE_LSB;

endmodule

// File: rtl/swsmi_period_lut.sv
module swsmi_period_lut
    import swsmi_pkg::*;
#(
    parameter int TICKS_PER_MS = 2,
    parameter int CNT_W        = 8
) (
    input  logic [RATE_W-1:0] rate_sel,
    output logic [CNT_W-1:0]  period
);

    logic [CNT_W-1:0] tbl [NUM_RATES];

    for (genvar gi = 0; gi < NUM_RATES; gi++) begin : g_rate
        localparam int PER_TICKS = rate_ticks(gi, TICKS_PER_MS);
        assign tbl[gi] = CNT_W'(PER_TICKS);
    end

    assign period = tbl[rate_sel];

endmodule

// File: rtl/swsmi_tick_counter.sv
module swsmi_tick_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] lim,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign at_last = (cnt == lim - CNT_W'(1));

endmodule

// File: rtl/swsmi_timer.sv
module swsmi_timer
    import swsmi_pkg::*;
#(
    parameter int TICKS_PER_MS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rtc_rst_n,
    input  logic             tmr_en,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             smi_timeout
);

    localparam int MAX_PER = rate_ticks(NUM_RATES - 1, TICKS_PER_MS);
    localparam int CNT_W   = $clog2(MAX_PER + 1);

    tmr_state_e        state_q, state_d;
    logic [RATE_W-1:0] rate_sel;
    logic [CNT_W-1:0]  per_sel;
    logic [CNT_W-1:0]  lim_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              at_last;
    logic              elapse;
    logic              cnt_clr;
    logic              lim_load;

    swsmi_cfg_reg u_cfg (
        .clk       (clk),
        .rtc_rst_n (rtc_rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rate_sel  (rate_sel),
        .rdata     (cfg_rdata)
    );

    swsmi_period_lut #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .CNT_W        (CNT_W)
    ) u_lut (
        .rate_sel (rate_sel),
        .period   (per_sel)
    );

    // A tick on the last count ends the interval.
    assign elapse   = tmr_en && tick && at_last && (state_q != TS_IDLE);
    assign cnt_clr  = (state_q == TS_IDLE) || !tmr_en || elapse;
    assign lim_load = (state_q == TS_IDLE) || elapse;

    swsmi_tick_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .adv     (tick),
        .lim     (lim_q),
        .cnt     (cnt_q),
        .at_last (at_last)
    );

    // Interval length: follows the register in IDLE, latched at each restart.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= CNT_W'(MAX_PER);
        end else if (lim_load) begin
            lim_q <= per_sel;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_IDLE: begin
                if (tmr_en) state_d = TS_RUN;               // start
            end
            TS_RUN: begin
                if (!tmr_en)      state_d = TS_IDLE;        // halt
                else if (elapse)  state_d = TS_EXPIRE;      // elapse
            end
            TS_EXPIRE: begin
                if (!tmr_en)      state_d = TS_IDLE;        // halt
                else if (elapse)  state_d = TS_EXPIRE;
                else              state_d = TS_RUN;         // resume
            end
            default: state_d = TS_IDLE;
        endcase
    end

    // Output process.
    always_comb begin
        smi_timeout = (state_q == TS_EXPIRE);
    end

endmodule

// File: rtl/swsmi_timer_chk.sv
module swsmi_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rtc_rst_n,
    input logic             tmr_en,
    input logic             tick,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic [7:0]       cfg_rdata,
    input logic             smi_timeout,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] lim
);

    // R1: a write lands in the rate field on the next cycle
    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rtc_rst_n)
        wr_en |=> cfg_rdata[7:6] == $past(wr_data[7:6]));

    // R3: without a write, the register holds, main reset included
    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rtc_rst_n)
        !wr_en |=> $stable(cfg_rdata));

    // R5: count never reaches the latched interval length
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < lim);

    // R6: pulse lasts one cycle
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smi_timeout |=> !smi_timeout);

    // R7: disabled timer stays quiet with a cleared count
    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |=> (!smi_timeout && cnt == '0));

    // R8: no tick, no expiry
    p_no_tick_no_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !smi_timeout);

endmodule

bind swsmi_timer swsmi_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rtc_rst_n   (rtc_rst_n),
    .tmr_en      (tmr_en),
    .tick        (tick),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .cfg_rdata   (cfg_rdata),
    .smi_timeout (smi_timeout),
    .cnt         (cnt_q),
    .lim         (lim_q)
);

// File: tb/swsmi_timer_tb.sv
module swsmi_timer_tb;

    localparam int CLK_P = 10;
    localparam int TPM   = 2;

    logic       clk = 1'b0;
    logic       rst_n, rtc_rst_n, tmr_en, tick, wr_en;
    logic [7:0] wr_data;
    logic [7:0] cfg_rdata;
    logic       smi_timeout;

    int    cyc = 0;
    int    compared = 0;
    int    mismatched = 0;
    int    pulse_cnt = 0;
    int    exp_q[$];
    string cur_req = "R5";

    swsmi_timer #(.TICKS_PER_MS(TPM)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rtc_rst_n   (rtc_rst_n),
        .tmr_en      (tmr_en),
        .tick        (tick),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .cfg_rdata   (cfg_rdata),
        .smi_timeout (smi_timeout)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // R4: expected interval lengths from the requirement
    function automatic int per_of(input int code);
        if (code == 0) return (3 * TPM + 1) / 2;
        return (16 * TPM) << (code - 1);
    endfunction

    // Monitor: pop expected pulse cycles and compare.
    always @(negedge clk) begin : mon
        int e;
        if (smi_timeout === 1'b1) begin
            pulse_cnt++;
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL %s: pulse at cycle %0d, expected none", cur_req, cyc);
            end else begin
                e = exp_q.pop_front();
                if (e != cyc) begin
                    mismatched++;
                    $display("FAIL %s: pulse at cycle %0d, expected cycle %0d", cur_req, cyc, e);
                end
            end
        end
    end

    task automatic check_val(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_drained(input string req);
        compared++;
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL %s: missing pulse, actual none expected cycle %0d", req, exp_q[0]);
            exp_q.delete();
        end
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [7:0] val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = val;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Driver: enable, push nk expected pulses, wait them out, disable.
    task automatic run_phase(input int code, input int nk, input string req);
        int c0;
        int p;
        p = per_of(code);
        @(negedge clk);
        cur_req = req;
        c0 = cyc;
        tmr_en = 1'b1;
        for (int k = 1; k <= nk; k++) exp_q.push_back(c0 + 1 + p * k);
        wait_until(c0 + 2 + p * nk);
        tmr_en = 1'b0;
        check_drained(req);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #(CLK_P * 200000);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int c0;
        int r;
        int seen;
        rst_n = 1'b0; rtc_rst_n = 1'b0; tmr_en = 1'b0;
        tick = 1'b1; wr_en = 1'b0; wr_data = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; rtc_rst_n = 1'b1;
        @(negedge clk);
        check_val("R2 reset value", cfg_rdata, 8'h00);
        check_val("R7 idle output", smi_timeout, 0);

        // R4/R5: each code, back-to-back pulses
        run_phase(0, 4, "R4 code00");
        write_cfg(8'h7F);
        check_val("R1 write 7F", cfg_rdata, 8'h40);
        run_phase(1, 2, "R4 code01");
        write_cfg(8'h80);
        check_val("R1 write 80", cfg_rdata, 8'h80);
        run_phase(2, 2, "R4 code10");
        write_cfg(8'hFF);
        check_val("R1 write FF", cfg_rdata, 8'hC0);
        run_phase(3, 2, "R5 code11");

        // R9: write mid-interval applies at the restart
        write_cfg(8'h00);
        @(negedge clk);
        cur_req = "R9";
        c0 = cyc;
        tmr_en = 1'b1;
        exp_q.push_back(c0 + 1 + 3);
        exp_q.push_back(c0 + 1 + 3 + 32);
        exp_q.push_back(c0 + 1 + 3 + 64);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h40;
        @(negedge clk);
        wr_en = 1'b0;
        wait_until(c0 + 2 + 3 + 64);
        tmr_en = 1'b0;
        check_drained("R9");
        repeat (2) @(negedge clk);

        // R8: five tick-less edges delay the pulse by five cycles
        @(negedge clk);
        cur_req = "R8";
        c0 = cyc;
        tmr_en = 1'b1;
        exp_q.push_back(c0 + 1 + 32 + 5);
        exp_q.push_back(c0 + 1 + 64 + 5);
        wait_until(c0 + 10);
        tick = 1'b0;
        wait_until(c0 + 15);
        tick = 1'b1;
        wait_until(c0 + 2 + 64 + 5);
        tmr_en = 1'b0;
        check_drained("R8");
        repeat (2) @(negedge clk);

        // R7: disable mid-interval, no pulse, full interval after re-enable
        @(negedge clk);
        cur_req = "R7";
        c0 = cyc;
        tmr_en = 1'b1;
        wait_until(c0 + 20);
        tmr_en = 1'b0;
        seen = pulse_cnt;
        wait_until(c0 + 60);
        check_val("R7 no pulse while disabled", pulse_cnt - seen, 0);
        run_phase(1, 1, "R7 re-enable");

        // R3: main reset mid-interval keeps the field, restarts the count
        write_cfg(8'hC0);
        @(negedge clk);
        cur_req = "R3";
        c0 = cyc;
        tmr_en = 1'b1;
        wait_until(c0 + 50);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_val("R3 output in reset", smi_timeout, 0);
        check_val("R3 field kept", cfg_rdata, 8'hC0);
        rst_n = 1'b1;
        r = cyc;
        exp_q.push_back(r + 1 + 128);
        wait_until(r + 2 + 128);
        tmr_en = 1'b0;
        check_drained("R3");
        repeat (2) @(negedge clk);

        // R2: RTC reset restores the shortest interval
        @(negedge clk);
        rtc_rst_n = 1'b0;
        @(negedge clk);
        rtc_rst_n = 1'b1;
        @(negedge clk);
        check_val("R2 cleared", cfg_rdata, 8'h00);
        write_cfg(8'h3F);
        check_val("R1 low bits ignored", cfg_rdata, 8'h00);
        run_phase(0, 3, "R2 shortest");

        summary();
        $finish;
    end

endmodule